// File: doc/BRIEF.md
# Bank auto-precharge timing tracker

The block follows the row state of every bank in a DDR SDRAM from a stream of decoded commands, one command per clock. A bank opens on an ACTIVE command. A READ issued with auto-precharge puts the bank into a bursting state. The bank closes itself once half a burst length has passed since that command, but never before the minimum row-active time since its ACTIVE. After that the bank sits in precharge for the row-precharge time and then becomes idle and ready to open again.

The tracker can sit beside a memory model or inside a controller as a checker. It reports the state of every bank and a per-bank ready-to-activate flag. A one-cycle illegal flag carries a cause code whenever a command breaks the bank rules: an ACTIVE to an open bank, an ACTIVE during precharge, a column command to a closed bank, or a column command that would cut into an auto-precharge burst. It also shows the clock cycles in which read data is on the bus. Every bank has its own counters, so traffic to one bank never waits on another bank.

Timing values (tRAS, tRP, CAS latency, burst length) are parameters given in clock cycles. The burst length must be even and at least 4. The defaults are tRAS=6, tRP=3, CL=3 and BL=4.

Top module: `apt_bank_tracker`

## Requirements
Command codes on `cmd`: 0 NOP, 1 ACTIVE, 2 READ, 3 READ with auto-precharge, 4 WRITE. Codes 5 to 7 act as NOP. State codes in each 2-bit field of `bank_state`: 0 idle, 1 open, 2 bursting, 3 precharging.

- R1: The reset takes effect as soon as `rst_n` goes low, and it holds for as long as `rst_n` stays low. During reset and after it, every `bank_state` field reads 0, `act_ready` is all ones, and both `illegal` and `rd_valid` are 0.
- R2: An ACTIVE (1) to an idle, ready bank gives that bank state 1 in the next cycle. Its `act_ready` bit goes low and no illegal flag is raised.
- R3: A READ with auto-precharge (3) to an open bank gives state 2 from the next cycle. If tRAS is already met by then, the bank shows state 3 from cycle c+BL/2, where c is the cycle of the command.
- R4: An auto-precharge never starts before cycle a+tRAS, where a is the cycle of the bank's ACTIVE. The precharge starts exactly at the later of a+tRAS and c+BL/2.
- R5: A bank stays in state 3 for exactly tRP cycles. It then shows state 0 with its `act_ready` bit high. An ACTIVE during precharge gives cause 2 and the bank stays in state 3.
- R6: A READ (2) or WRITE (4) to a bank in state 2 gives cause 4. The burst and the start of its precharge are unchanged.
- R7: A READ or WRITE to a bank in state 0 or 3 gives cause 3. The bank state does not change and no read data window opens.
- R8: An ACTIVE to a bank in state 1 or 2 gives cause 1. The row-active count is not restarted, so a later auto-precharge keeps to the original ACTIVE.
- R9: `illegal` is 1 and `illegal_cause` holds the cause only in the cycle right after the offending command. After a legal command both read 0. Cause codes: 0 none, 1 ACTIVE to an open bank, 2 ACTIVE during precharge, 3 column command to a closed bank, 4 column command into an auto-precharge burst.
- R10: After an accepted READ or READ with auto-precharge in cycle c, `rd_valid` is high in cycles c+CL through c+CL+BL-1. Overlapping windows merge.
- R11: Banks are independent, and bank i occupies bits [2i+1:2i] of `bank_state`. A command to one bank is accepted whatever state another bank is in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| cmd | input | 3 | Decoded command code for this cycle |
| cmd_bank | input | 2 | Bank addressed by the command |
| bank_state | output | 8 | Packed 2-bit state of each bank |
| act_ready | output | 4 | Per bank: an ACTIVE would be accepted now |
| illegal | output | 1 | The command of the previous cycle broke a bank rule |
| illegal_cause | output | 3 | Cause code for `illegal` |
| rd_valid | output | 1 | Read data is on the bus in this cycle |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the half-burst point of an auto-precharge read and the expiry of tRAS. The bench issues the read exactly four cycles after the ACTIVE, so that both land in cycle six. It then checks that the bank is still bursting one cycle earlier and is precharging in that very cycle. The second pair is a column command issued in the last bursting cycle, together with the precharge start that follows it. That command must report the burst-interrupt cause, 4, and not the closed-bank cause. The precharge must still start on time, and a READ issued one cycle later must report cause 3.

// File: rtl/apt_pkg.sv
package apt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_RDA = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    BS_IDLE  = 2'd0,
    BS_OPEN  = 2'd1,
    BS_BURST = 2'd2,
    BS_PRE   = 2'd3
  } bstate_e;

  typedef enum logic [2:0] {
    EC_NONE       = 3'd0,
    EC_ACT_OPEN   = 3'd1,
    EC_ACT_PRE    = 3'd2,
    EC_COL_CLOSED = 3'd3,
    EC_CAS_INT    = 3'd4
  } ecause_e;

  // per-bank view of the command in this cycle
  typedef struct packed {
    logic act;  // row open request
    logic col;  // any column command
    logic ap;   // column command with auto-precharge
    logic rd;   // column command that returns data
  } op_t;

endpackage

// File: rtl/apt_cmd_dec.sv
module apt_cmd_dec
  import apt_pkg::*;
#(
  parameter int NB = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic [2:0]     cmd,
  input  logic [BW-1:0]  bank,
  output op_t [NB-1:0]   ops
);

  op_t op_c;

  always_comb begin
    op_c = '0;
    case (cmd)
      CMD_ACT: op_c.act = 1'b1;
      CMD_RD:  begin op_c.col = 1'b1; op_c.rd = 1'b1; end
      CMD_RDA: begin op_c.col = 1'b1; op_c.rd = 1'b1; op_c.ap = 1'b1; end
      CMD_WR:  op_c.col = 1'b1;
      default: op_c = '0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      ops[i] = (bank == BW'(i)) ? op_c : '0;
    end
  end

endmodule

// File: rtl/apt_bank.sv
module apt_bank
  import apt_pkg::*;
#(
  parameter int TRAS = 6,
  parameter int TRP  = 3,
  parameter int HALF = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  op_t     op,
  output bstate_e st,
  output logic    ready,
  output ecause_e err,
  output logic    rd_go
);

  localparam int RASW = $clog2(TRAS + 1);
  localparam int RPW  = (TRP > 1) ? $clog2(TRP) : 1;
  localparam int HW   = $clog2(HALF + 1);
  localparam logic [RASW-1:0] RAS_FULL  = RASW'(TRAS);
  localparam logic [RASW-1:0] RAS_LAST  = RASW'(TRAS - 1);
  localparam logic [HW-1:0]   HALF_FULL = HW'(HALF);
  localparam logic [HW-1:0]   HALF_LAST = HW'(HALF - 1);
  localparam logic [RPW-1:0]  RP_LOAD   = RPW'(TRP - 1);

  bstate_e         st_q, st_d;
  logic [RASW-1:0] ras_q, ras_d;   // cycles since ACTIVE, saturating
  logic [HW-1:0]   bl_q, bl_d;     // cycles since auto-precharge read
  logic [RPW-1:0]  rp_q, rp_d;     // precharge cycles left after this one
  logic            cnt_en;

  always_comb begin
    st_d   = st_q;
    ras_d  = ras_q;
    bl_d   = bl_q;
    rp_d   = rp_q;
    err    = EC_NONE;
    rd_go  = 1'b0;
    cnt_en = 1'b0;
    case (st_q)
      BS_IDLE: begin
        if (op.act) begin
          st_d   = BS_OPEN;
          ras_d  = RASW'(1);
          cnt_en = 1'b1;
        end else if (op.col) begin
          err = EC_COL_CLOSED;
        end
      end
      BS_OPEN: begin
        cnt_en = 1'b1;
        if (ras_q != RAS_FULL) ras_d = ras_q + 1'b1;
        if (op.act) begin
          err = EC_ACT_OPEN;
        end else if (op.col) begin
          rd_go = op.rd;
          if (op.ap) begin
            st_d = BS_BURST;
            bl_d = HW'(1);
          end
        end
      end
      BS_BURST: begin
        cnt_en = 1'b1;
        if (ras_q != RAS_FULL) ras_d = ras_q + 1'b1;
        if (bl_q != HALF_FULL) bl_d = bl_q + 1'b1;
        if (op.act)      err = EC_ACT_OPEN;
        else if (op.col) err = EC_CAS_INT;
        // both limits are met in the coming cycle
        if (bl_q >= HALF_LAST && ras_q >= RAS_LAST) begin
          st_d = BS_PRE;
          rp_d = RP_LOAD;
        end
      end
      BS_PRE: begin
        cnt_en = 1'b1;
        if (op.act)      err = EC_ACT_PRE;
        else if (op.col) err = EC_COL_CLOSED;
        if (rp_q == '0) begin
          st_d  = BS_IDLE;
          ras_d = '0;
          bl_d  = '0;
        end else begin
          rp_d = rp_q - 1'b1;
        end
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BS_IDLE;
      ras_q <= '0;
      bl_q  <= '0;
      rp_q  <= '0;
    end else if (cnt_en) begin
      st_q  <= st_d;
      ras_q <= ras_d;
      bl_q  <= bl_d;
      rp_q  <= rp_d;
    end
  end

  assign st    = st_q;
  assign ready = (st_q == BS_IDLE) && (rp_q == '0);

  p_rda_enters_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_OPEN && op.ap) |=> (st_q == BS_BURST));

  p_pre_after_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_BURST) |=> (st_q != BS_PRE || ras_q == RAS_FULL));

  p_act_blocked_in_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_PRE && op.act) |=> (st_q != BS_OPEN));

  p_cas_int_keeps_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_BURST && op.col) |=> (st_q == BS_BURST || st_q == BS_PRE));

  p_col_closed_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_IDLE && op.col) |=> (st_q == BS_IDLE));

endmodule

// File: rtl/apt_rd_window.sv
module apt_rd_window #(
  parameter int CL = 3,
  parameter int BL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic rd_valid
);

  // tap i holds a read issued i+1 cycles ago
  localparam int SL = CL + BL - 1;

  logic [SL-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SL-2:0], go};
  end

  assign rd_valid = |sh_q[SL-1:CL-1];

endmodule

// File: rtl/apt_bank_tracker.sv
module apt_bank_tracker
  import apt_pkg::*;
#(
  parameter int NB   = 4,
  parameter int TRAS = 6,
  parameter int TRP  = 3,
  parameter int CL   = 3,
  parameter int BL   = 4,
  localparam int BW  = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cmd,
  input  logic [BW-1:0]   cmd_bank,
  output logic [2*NB-1:0] bank_state,
  output logic [NB-1:0]   act_ready,
  output logic            illegal,
  output logic [2:0]      illegal_cause,
  output logic            rd_valid
);

  // reset: immediate assertion, release after two clock edges
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  op_t [NB-1:0] ops;
  ecause_e      errs [NB];
  logic [NB-1:0] go_w;

  apt_cmd_dec #(.NB(NB)) u_dec (
    .cmd  (cmd),
    .bank (cmd_bank),
    .ops  (ops)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    bstate_e st_w;
    apt_bank #(.TRAS(TRAS), .TRP(TRP), .HALF(BL / 2)) u_bank (
      .clk   (clk),
      .rst_n (rst_i),
      .op    (ops[g]),
      .st    (st_w),
      .ready (act_ready[g]),
      .err   (errs[g]),
      .rd_go (go_w[g])
    );
    assign bank_state[2*g +: 2] = st_w;
  end

  logic [2:0] err_or;
  always_comb begin
    err_or = '0;
    for (int i = 0; i < NB; i++) err_or = err_or | errs[i];
  end

  logic       ill_q;
  logic [2:0] cause_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ill_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      ill_q   <= (err_or != '0);
      cause_q <= err_or;
    end
  end

  assign illegal       = ill_q;
  assign illegal_cause = cause_q;

  apt_rd_window #(.CL(CL), .BL(BL)) u_rdw (
    .clk      (clk),
    .rst_n    (rst_i),
    .go       (|go_w),
    .rd_valid (rd_valid)
  );

  p_illegal_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_i)
    illegal |-> ($past(cmd) != 3'd0));

endmodule

// File: tb/sim_apt_bank_tracker.sv
module sim_apt_bank_tracker;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                         C_RDA = 3'd3, C_WR = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = C_NOP;
  logic [1:0] bnk = 2'd0;
  logic [7:0] bank_state;
  logic [3:0] act_ready;
  logic       illegal;
  logic [2:0] illegal_cause;
  logic       rd_valid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  apt_bank_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(bnk),
    .bank_state(bank_state), .act_ready(act_ready), .illegal(illegal),
    .illegal_cause(illegal_cause), .rd_valid(rd_valid)
  );

  // fields: cmd, bank, illegal, cause, bank_state, act_ready, rd_valid
  localparam logic [21:0] VEC [19] = '{
    {C_ACT, 2'd0, 1'b0, 3'd0, 8'h01, 4'b1110, 1'b0},
    {C_RDA, 2'd0, 1'b0, 3'd0, 8'h02, 4'b1110, 1'b0},
    {C_RD,  2'd0, 1'b1, 3'd4, 8'h02, 4'b1110, 1'b0},
    {C_ACT, 2'd1, 1'b0, 3'd0, 8'h06, 4'b1100, 1'b1},
    {C_NOP, 2'd0, 1'b0, 3'd0, 8'h06, 4'b1100, 1'b1},
    {C_ACT, 2'd0, 1'b1, 3'd1, 8'h07, 4'b1100, 1'b1},
    {C_ACT, 2'd0, 1'b1, 3'd2, 8'h07, 4'b1100, 1'b1},
    {C_RD,  2'd1, 1'b0, 3'd0, 8'h07, 4'b1100, 1'b0},
    {C_WR,  2'd0, 1'b1, 3'd3, 8'h04, 4'b1101, 1'b0},
    {C_ACT, 2'd0, 1'b0, 3'd0, 8'h05, 4'b1100, 1'b1},
    {C_RDA, 2'd1, 1'b0, 3'd0, 8'h09, 4'b1100, 1'b1},
    {C_WR,  2'd2, 1'b1, 3'd3, 8'h0D, 4'b1100, 1'b1},
    {C_RDA, 2'd0, 1'b0, 3'd0, 8'h0E, 4'b1100, 1'b1},
    {C_NOP, 2'd0, 1'b0, 3'd0, 8'h0E, 4'b1100, 1'b1},
    {C_NOP, 2'd0, 1'b0, 3'd0, 8'h03, 4'b1110, 1'b1},
    {C_NOP, 2'd0, 1'b0, 3'd0, 8'h03, 4'b1110, 1'b1},
    {C_NOP, 2'd0, 1'b0, 3'd0, 8'h03, 4'b1110, 1'b1},
    {C_NOP, 2'd0, 1'b0, 3'd0, 8'h00, 4'b1111, 1'b1},
    {C_NOP, 2'd0, 1'b0, 3'd0, 8'h00, 4'b1111, 1'b0}
  };

  function automatic int fld(int i);
    return int'(bank_state[2*i +: 2]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // present a command for one cycle; return where its effect is visible
  task automatic step(logic [2:0] c, logic [1:0] b);
    cmd = c;
    bnk = b;
    @(negedge clk);
    cmd = C_NOP;
    bnk = 2'd0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [21:0] v;
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    chk("R1 state in reset", int'(bank_state), 0);
    chk("R1 ready in reset", int'(act_ready), 15);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 state after reset", int'(bank_state), 0);
    chk("R1 ready after reset", int'(act_ready), 15);
    chk("R1 illegal after reset", int'(illegal), 0);
    chk("R1 rd_valid after reset", int'(rd_valid), 0);

    // vector walk
    for (int k = 0; k < 19; k++) begin
      v = VEC[k];
      step(v[21:19], v[18:17]);
      chk($sformatf("R9 illegal row %0d", k), int'(illegal), int'(v[16]));
      chk($sformatf("R9 cause row %0d", k), int'(illegal_cause), int'(v[15:13]));
      chk($sformatf("R3 bank_state row %0d", k), int'(bank_state), int'(v[12:5]));
      chk($sformatf("R5 act_ready row %0d", k), int'(act_ready), int'(v[4:1]));
      chk($sformatf("R10 rd_valid row %0d", k), int'(rd_valid), int'(v[0]));
    end

    // half-burst point and tRAS expiry in the same cycle
    step(C_ACT, 2'd2);                           // cycle 0
    chk("R2 bank2 open", fld(2), 1);
    chk("R2 bank2 not ready", int'(act_ready[2]), 0);
    chk("R2 no illegal", int'(illegal), 0);
    repeat (3) step(C_NOP, 2'd0);                // cycles 1..3
    step(C_RDA, 2'd2);                           // cycle 4
    chk("R4 still bursting", fld(2), 2);
    step(C_WR, 2'd2);                            // cycle 5, last burst cycle
    chk("R4 precharge on time", fld(2), 3);
    chk("R6 illegal", int'(illegal), 1);
    chk("R6 cause", int'(illegal_cause), 4);
    step(C_RD, 2'd2);                            // cycle 6
    chk("R7 cause", int'(illegal_cause), 3);
    chk("R7 state kept", fld(2), 3);
    step(C_NOP, 2'd0);                           // cycle 7
    chk("R5 precharge held", fld(2), 3);
    chk("R5 not ready", int'(act_ready[2]), 0);
    step(C_ACT, 2'd3);                           // cycle 8
    chk("R5 idle after tRP", fld(2), 0);
    chk("R5 ready after tRP", int'(act_ready[2]), 1);
    chk("R11 bank3 open", fld(3), 1);
    chk("R11 no illegal", int'(illegal), 0);
    step(C_NOP, 2'd0);                           // cycle 9
    chk("R10 last data cycle", int'(rd_valid), 1);
    step(C_NOP, 2'd0);                           // cycle 10
    chk("R10 window closed", int'(rd_valid), 0);

    // second ACTIVE must not restart the row-active count
    step(C_ACT, 2'd3);                           // cycle 11
    chk("R8 cause", int'(illegal_cause), 1);
    chk("R8 still open", fld(3), 1);
    step(C_RDA, 2'd3);                           // cycle 12
    chk("R8 bursting", fld(3), 2);
    step(C_NOP, 2'd0);                           // cycle 13
    chk("R8 timer kept", fld(3), 3);
    repeat (5) step(C_NOP, 2'd0);                // to cycle 19
    chk("R5 bank3 idle", fld(3), 0);
    chk("R10 quiet", int'(rd_valid), 0);

    // rejected read opens no data window
    step(C_RD, 2'd0);
    chk("R7 closed bank cause", int'(illegal_cause), 3);
    chk("R7 bank0 idle", fld(0), 0);
    for (int k = 0; k < 7; k++) begin
      chk("R10 no data after rejected read", int'(rd_valid), 0);
      step(C_NOP, 2'd0);
    end

    // auto-precharge read long after tRAS
    step(C_ACT, 2'd1);
    repeat (8) step(C_NOP, 2'd0);
    step(C_RDA, 2'd1);
    chk("R3 bursting", fld(1), 2);
    step(C_NOP, 2'd0);
    chk("R3 precharge at half burst", fld(1), 3);
    step(C_NOP, 2'd0);
    chk("R10 first data cycle", int'(rd_valid), 1);

    // reset while busy
    rst_n = 1'b0;
    #1;
    chk("R1 async state", int'(bank_state), 0);
    chk("R1 async ready", int'(act_ready), 15);
    chk("R1 async rd_valid", int'(rd_valid), 0);
    chk("R1 async illegal", int'(illegal), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule